// File: doc/BRIEF.md
# Banked Two-Port Synchronous Word Store

This block is a two-port synchronous memory. Each port has its own clock, chip selects, address, data, half-word enables, read/write control and output enable. The word space is divided into equal banks. The top address bits pick a bank and the low bits pick a word inside it. Either port may use any bank that the other port is not using in the same cycle. Keeping the ports apart is left to the system, which steers the bank bits. When the two ports do meet in one bank, a flag on each port reports it. Both accesses still complete.

Every input is registered on the rising edge of its port clock. Each port has an address counter that can be loaded, stepped, held, or sent back to the last loaded start address, so bursts need no address traffic. A mode pin per port selects between a flow-through read and a pipelined read that is one cycle later. A depth of 64 banks of 4096 words is reached by setting the bank-width and offset-width parameters to 6 and 12. The defaults, 3 and 6, give 8 banks of 64 words.

Conflict flagging and the same-word write rule assume that both port clocks come from one source. The single reset `rst_n` is sampled synchronously in each port's clock domain.

Top module: `dpbank_mem`

## Requirements
- R1: A clock edge with `rst_n` low clears every port register. In the cycle after the reset is released, `dvalid_*`, `dout_*` and `conflict_*` are all 0.
- R2: A bank is chosen by the top BANK_W address bits, which are bits 8:6 by default. Two accesses with the same offset bits in different banks do not conflict.
- R3: A port is selected only when `ce0_n_*` is 0 and `ce1_*` is 1 at the capturing edge. A port that is not selected writes nothing, its `dvalid_*` is 0 for that access, and it raises no conflict.
- R4: `be_*[0]` enables bits 8:0 of a write and `be_*[1]` enables bits 17:9. Halves that are not enabled keep their old contents.
- R5: In flow-through mode (`pipe_*`=0), a read captured at edge k drives its data and `dvalid_*` during the cycle between edges k and k+1.
- R6: In pipelined mode (`pipe_*`=1), the same read appears one cycle later, between edges k+1 and k+2.
- R7: The access address comes from the captured controls in this order. `load_*` uses the external address and also records it as the start address. Otherwise `rewind_*` uses the start address. Otherwise `step_*` uses the counter plus one. Otherwise the counter holds its value. The counter always takes the access address, whether or not the port is selected.
- R8: Stepping from the top address (all ones) wraps the counter to 0.
- R9: A write captured at edge k is visible to a read from either port that is captured at edge k+1 or later.
- R10: When both ports are selected and their access addresses share a bank, both `conflict_*` outputs are 1 for that cycle. Reads still return the stored data and writes still complete.
- R11: When both ports write the same half of the same word in the same cycle, port A's value is kept. Halves that only port B writes take port B's value.
- R12: When `oe_*` is 0, that port shows `dvalid_*`=0 and `dout_*`=0, whatever read is in its output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce0_n_a | input | 1 | Port A select, active low |
| ce1_a | input | 1 | Port A select, active high |
| we_a | input | 1 | Port A write (1) or read (0) |
| be_a | input | 2 | Port A half-word enables |
| addr_a | input | 9 | Port A external address |
| load_a | input | 1 | Port A load external address |
| step_a | input | 1 | Port A advance counter |
| rewind_a | input | 1 | Port A return to start address |
| pipe_a | input | 1 | Port A read mode, 1 = pipelined |
| oe_a | input | 1 | Port A output enable |
| din_a | input | 18 | Port A write data |
| dout_a | output | 18 | Port A read data (0 when not valid) |
| dvalid_a | output | 1 | Port A read data valid |
| conflict_a | output | 1 | Port A same-bank flag |
| ce0_n_b | input | 1 | Port B select, active low |
| ce1_b | input | 1 | Port B select, active high |
| we_b | input | 1 | Port B write (1) or read (0) |
| be_b | input | 2 | Port B half-word enables |
| addr_b | input | 9 | Port B external address |
| load_b | input | 1 | Port B load external address |
| step_b | input | 1 | Port B advance counter |
| rewind_b | input | 1 | Port B return to start address |
| pipe_b | input | 1 | Port B read mode, 1 = pipelined |
| oe_b | input | 1 | Port B output enable |
| din_b | input | 18 | Port B write data |
| dout_b | output | 18 | Port B read data (0 when not valid) |
| dvalid_b | output | 1 | Port B read data valid |
| conflict_b | output | 1 | Port B same-bank flag |

## Verification
The assertions check the counter's behaviour on every cycle: a load lands on the captured address, the counter holds when no control is active, and a step from all ones wraps to zero. They also check that the two ports always agree on a bank conflict. Data-related behaviour can only be shown by the bench's scenarios, which are compared against a behavioural model. This covers flow-through versus pipelined latency, half-word merging, visibility of a write to the other port, the port A priority on a shared word, deselection by either select pin, and output gating.

// File: rtl/dpbank_pkg.sv
// Shared definitions for the banked two-port store.
// Assumes: a word is split into two equal halves, each with its own enable.
package dpbank_pkg;
    typedef enum logic {RD_FLOW = 1'b0, RD_PIPE = 1'b1} rd_mode_e;
    localparam int NUM_HALVES = 2;
endpackage

// File: rtl/dpbank_port.sv
// One access port: input capture, burst address counter, read output stage
// and same-bank detection against the peer port.
// Assumes: rdata is the combinational storage read at acc_addr; the peer's
// sel_q/bank_q come from the same clock source when conflicts matter.
module dpbank_port
    import dpbank_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce0_n,
    input  logic                      ce1,
    input  logic                      we,
    input  logic [NUM_HALVES-1:0]     be,
    input  logic [BANK_W+OFF_W-1:0]   addr,
    input  logic                      load,
    input  logic                      step,
    input  logic                      rewind,
    input  logic                      pipe,
    input  logic                      oe,
    input  logic [DATA_W-1:0]         din,
    input  logic [DATA_W-1:0]         rdata,
    input  logic                      peer_sel,
    input  logic [BANK_W-1:0]         peer_bank,
    output logic [BANK_W+OFF_W-1:0]   acc_addr,
    output logic [NUM_HALVES-1:0]     wen,
    output logic [DATA_W-1:0]         wdata,
    output logic                      sel_q,
    output logic [BANK_W-1:0]         bank_q,
    output logic [DATA_W-1:0]         dout,
    output logic                      dvalid,
    output logic                      conflict
);
    localparam int AW = BANK_W + OFF_W;

    logic                  sel_r, we_r, load_r, step_r, rewind_r;
    logic [NUM_HALVES-1:0] be_r;
    logic [AW-1:0]         addr_r, cnt, start, acc;
    logic [DATA_W-1:0]     din_r, pipe_d, slot_d;
    logic                  pipe_v, rd_slot, slot_v;
    rd_mode_e              mode;

    // Capture every input on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r    <= 1'b0;
            we_r     <= 1'b0;
            be_r     <= '0;
            addr_r   <= '0;
            load_r   <= 1'b0;
            step_r   <= 1'b0;
            rewind_r <= 1'b0;
            din_r    <= '0;
        end else begin
            sel_r    <= !ce0_n && ce1;
            we_r     <= we;
            be_r     <= be;
            addr_r   <= addr;
            load_r   <= load;
            step_r   <= step;
            rewind_r <= rewind;
            din_r    <= din;
        end
    end

    // Pick this cycle's access address: load, then rewind, then step, else hold.
    always_comb begin
        if (load_r)        acc = addr_r;
        else if (rewind_r) acc = start;
        else if (step_r)   acc = cnt + 1'b1;
        else               acc = cnt;
    end

    // Keep the counter on the access address and record loaded start points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            start <= '0;
        end else begin
            cnt <= acc;
            if (load_r) start <= addr_r;
        end
    end

    assign acc_addr = acc;
    assign wen      = (sel_r && we_r) ? be_r : '0;
    assign wdata    = din_r;
    assign sel_q    = sel_r;
    assign bank_q   = acc[AW-1 -: BANK_W];
    assign rd_slot  = sel_r && !we_r;

    // Extra output register used by the pipelined read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= 1'b0;
            pipe_d <= '0;
        end else begin
            pipe_v <= rd_slot;
            pipe_d <= rdata;
        end
    end

    assign mode = rd_mode_e'(pipe);

    // Select the read slot that matches the chosen latency.
    always_comb begin
        if (mode == RD_PIPE) begin
            slot_v = pipe_v;
            slot_d = pipe_d;
        end else begin
            slot_v = rd_slot;
            slot_d = rdata;
        end
    end

    assign dvalid   = oe && slot_v;
    assign dout     = dvalid ? slot_d : '0;
    assign conflict = sel_r && peer_sel && (bank_q == peer_bank);

    // R7
    load_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_r |=> cnt == $past(addr_r));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_r && !rewind_r && !step_r) |=> cnt == $past(cnt));
    // R8
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_r && !load_r && !rewind_r && (&cnt)) |=> cnt == '0);
endmodule

// File: rtl/dpbank_store.sv
// Word storage with one write path per port clock. Each half-word has a copy
// per port plus a one-bit tag per port; the tags together name the most
// recent writer, so no array has two drivers.
// Assumes: when both ports hit the same half in one cycle the clocks are common,
// and port B then skips its write so port A's data stays.
module dpbank_store
    import dpbank_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 18
) (
    input  logic                    clk_a,
    input  logic                    clk_b,
    input  logic                    rst_n,
    input  logic [BANK_W+OFF_W-1:0] a_addr,
    input  logic [NUM_HALVES-1:0]   a_wen,
    input  logic [DATA_W-1:0]       a_wdata,
    input  logic [BANK_W+OFF_W-1:0] b_addr,
    input  logic [NUM_HALVES-1:0]   b_wen,
    input  logic [DATA_W-1:0]       b_wdata,
    output logic [DATA_W-1:0]       a_rdata,
    output logic [DATA_W-1:0]       b_rdata
);
    localparam int AW    = BANK_W + OFF_W;
    localparam int DEPTH = 1 << AW;
    localparam int HW    = DATA_W / NUM_HALVES;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic [HW-1:0] mem_a [DEPTH];
        logic [HW-1:0] mem_b [DEPTH];
        logic          tag_a [DEPTH];
        logic          tag_b [DEPTH];
        logic          b_go;

        assign b_go = b_wen[h] && !(a_wen[h] && (a_addr == b_addr));

        // Port A data copy.
        always_ff @(posedge clk_a) begin
            if (a_wen[h]) mem_a[a_addr] <= a_wdata[h*HW +: HW];
        end

        // Port A tag: equal tags mean port A wrote last.
        always_ff @(posedge clk_a) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) tag_a[i] <= 1'b0;
            end else if (a_wen[h]) begin
                tag_a[a_addr] <= tag_b[a_addr];
            end
        end

        // Port B data copy, yielding to a same-cycle port A write.
        always_ff @(posedge clk_b) begin
            if (b_go) mem_b[b_addr] <= b_wdata[h*HW +: HW];
        end

        // Port B tag: differing tags mean port B wrote last.
        always_ff @(posedge clk_b) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) tag_b[i] <= 1'b0;
            end else if (b_go) begin
                tag_b[b_addr] <= !tag_a[b_addr];
            end
        end

        assign a_rdata[h*HW +: HW] = (tag_a[a_addr] == tag_b[a_addr]) ? mem_a[a_addr] : mem_b[a_addr];
        assign b_rdata[h*HW +: HW] = (tag_a[b_addr] == tag_b[b_addr]) ? mem_a[b_addr] : mem_b[b_addr];
    end
endmodule

// File: rtl/dpbank_mem.sv
// Top of the banked two-port store: two identical ports around one storage.
// Assumes: conflict flags compare accesses of the same cycle, so both port
// clocks come from one source when the flags are used.
module dpbank_mem
    import dpbank_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 18
) (
    input  logic                    clk_a,
    input  logic                    clk_b,
    input  logic                    rst_n,
    input  logic                    ce0_n_a,
    input  logic                    ce1_a,
    input  logic                    we_a,
    input  logic [1:0]              be_a,
    input  logic [BANK_W+OFF_W-1:0] addr_a,
    input  logic                    load_a,
    input  logic                    step_a,
    input  logic                    rewind_a,
    input  logic                    pipe_a,
    input  logic                    oe_a,
    input  logic [DATA_W-1:0]       din_a,
    output logic [DATA_W-1:0]       dout_a,
    output logic                    dvalid_a,
    output logic                    conflict_a,
    input  logic                    ce0_n_b,
    input  logic                    ce1_b,
    input  logic                    we_b,
    input  logic [1:0]              be_b,
    input  logic [BANK_W+OFF_W-1:0] addr_b,
    input  logic                    load_b,
    input  logic                    step_b,
    input  logic                    rewind_b,
    input  logic                    pipe_b,
    input  logic                    oe_b,
    input  logic [DATA_W-1:0]       din_b,
    output logic [DATA_W-1:0]       dout_b,
    output logic                    dvalid_b,
    output logic                    conflict_b
);
    localparam int AW = BANK_W + OFF_W;

    logic [AW-1:0]         acc_a, acc_b;
    logic [NUM_HALVES-1:0] wen_a, wen_b;
    logic [DATA_W-1:0]     wd_a, wd_b, rd_a, rd_b;
    logic                  sel_a, sel_b;
    logic [BANK_W-1:0]     bank_a, bank_b;

    dpbank_port #(.BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_port_a (
        .clk(clk_a), .rst_n(rst_n), .ce0_n(ce0_n_a), .ce1(ce1_a), .we(we_a),
        .be(be_a), .addr(addr_a), .load(load_a), .step(step_a), .rewind(rewind_a),
        .pipe(pipe_a), .oe(oe_a), .din(din_a), .rdata(rd_a),
        .peer_sel(sel_b), .peer_bank(bank_b),
        .acc_addr(acc_a), .wen(wen_a), .wdata(wd_a), .sel_q(sel_a), .bank_q(bank_a),
        .dout(dout_a), .dvalid(dvalid_a), .conflict(conflict_a)
    );

    dpbank_port #(.BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_port_b (
        .clk(clk_b), .rst_n(rst_n), .ce0_n(ce0_n_b), .ce1(ce1_b), .we(we_b),
        .be(be_b), .addr(addr_b), .load(load_b), .step(step_b), .rewind(rewind_b),
        .pipe(pipe_b), .oe(oe_b), .din(din_b), .rdata(rd_b),
        .peer_sel(sel_a), .peer_bank(bank_a),
        .acc_addr(acc_b), .wen(wen_b), .wdata(wd_b), .sel_q(sel_b), .bank_q(bank_b),
        .dout(dout_b), .dvalid(dvalid_b), .conflict(conflict_b)
    );

    dpbank_store #(.BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_addr(acc_a), .a_wen(wen_a), .a_wdata(wd_a),
        .b_addr(acc_b), .b_wen(wen_b), .b_wdata(wd_b),
        .a_rdata(rd_a), .b_rdata(rd_b)
    );

    // R10
    conflict_pair_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        conflict_a == conflict_b);
endmodule

// File: tb/dpbank_mem_test.sv
`timescale 1ns/1ps
module dpbank_mem_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        ce0n [2];
    logic        ce1  [2];
    logic        we   [2];
    logic [1:0]  be   [2];
    logic [8:0]  addr [2];
    logic        ld   [2];
    logic        st   [2];
    logic        rw   [2];
    logic        pipe [2];
    logic        oe   [2];
    logic [17:0] din  [2];
    logic [17:0] dout [2];
    logic        dval [2];
    logic        conf [2];

    dpbank_mem uut (
        .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
        .ce0_n_a(ce0n[0]), .ce1_a(ce1[0]), .we_a(we[0]), .be_a(be[0]), .addr_a(addr[0]),
        .load_a(ld[0]), .step_a(st[0]), .rewind_a(rw[0]), .pipe_a(pipe[0]), .oe_a(oe[0]),
        .din_a(din[0]), .dout_a(dout[0]), .dvalid_a(dval[0]), .conflict_a(conf[0]),
        .ce0_n_b(ce0n[1]), .ce1_b(ce1[1]), .we_b(we[1]), .be_b(be[1]), .addr_b(addr[1]),
        .load_b(ld[1]), .step_b(st[1]), .rewind_b(rw[1]), .pipe_b(pipe[1]), .oe_b(oe[1]),
        .din_b(din[1]), .dout_b(dout[1]), .dvalid_b(dval[1]), .conflict_b(conf[1])
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur = "R1";

    // Behavioural reference state.
    logic [17:0] mm [512];
    logic [8:0]  m_cnt [2], m_start [2], m_pa [2];
    logic        m_pw [2], m_fv [2], m_pv [2], m_sel [2];
    logic [2:0]  m_bk [2];
    logic [1:0]  m_pbe [2];
    logic [17:0] m_fd [2], m_pd [2], m_pdin [2];

    initial for (int i = 0; i < 512; i++) mm[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_cnt[p] = 0; m_start[p] = 0; m_pa[p] = 0; m_pw[p] = 0;
                m_fv[p] = 0; m_pv[p] = 0; m_sel[p] = 0; m_bk[p] = 0;
                m_pbe[p] = 0; m_fd[p] = 0; m_pd[p] = 0; m_pdin[p] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                m_pv[p] = m_fv[p];
                m_pd[p] = m_fd[p];
            end
            // port B first, so port A overrides a shared half
            for (int q = 1; q >= 0; q--) if (m_pw[q]) begin
                if (m_pbe[q][0]) mm[m_pa[q]][8:0]  = m_pdin[q][8:0];
                if (m_pbe[q][1]) mm[m_pa[q]][17:9] = m_pdin[q][17:9];
            end
            for (int p = 0; p < 2; p++) begin
                logic [8:0] a;
                logic       s;
                s = !ce0n[p] && ce1[p];
                if (ld[p])      a = addr[p];
                else if (rw[p]) a = m_start[p];
                else if (st[p]) a = m_cnt[p] + 9'd1;
                else            a = m_cnt[p];
                if (ld[p]) m_start[p] = addr[p];
                m_cnt[p]  = a;
                m_sel[p]  = s;
                m_bk[p]   = a[8:6];
                m_pw[p]   = s && we[p];
                m_pa[p]   = a;
                m_pbe[p]  = be[p];
                m_pdin[p] = din[p];
                m_fv[p]   = s && !we[p];
                m_fd[p]   = mm[a];
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model once per cycle.
    always @(negedge clk) if (armed) begin
        for (int p = 0; p < 2; p++) begin
            logic        ev, ec;
            logic [17:0] ed;
            ev = oe[p] && (pipe[p] ? m_pv[p] : m_fv[p]);
            ed = ev ? (pipe[p] ? m_pd[p] : m_fd[p]) : 18'h0;
            ec = m_sel[0] && m_sel[1] && (m_bk[0] == m_bk[1]);
            chk(cur, p == 0 ? "dvalid_a" : "dvalid_b", {17'b0, dval[p]}, {17'b0, ev});
            chk(cur, p == 0 ? "dout_a" : "dout_b", dout[p], ed);
            chk(cur, p == 0 ? "conflict_a" : "conflict_b", {17'b0, conf[p]}, {17'b0, ec});
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic put(input int p, input logic c0n, input logic c1, input logic w,
                       input logic [1:0] b, input logic [8:0] ad, input logic l,
                       input logic s, input logic r, input logic [17:0] d);
        ce0n[p] = c0n; ce1[p] = c1; we[p] = w; be[p] = b; addr[p] = ad;
        ld[p] = l; st[p] = s; rw[p] = r; din[p] = d;
    endtask

    task automatic idle(input int p);
        put(p, 1'b1, 1'b0, 1'b0, 2'b00, 9'h0, 1'b0, 1'b0, 1'b0, 18'h0);
    endtask

    task automatic wr(input int p, input logic [8:0] ad, input logic [1:0] b, input logic [17:0] d);
        put(p, 1'b0, 1'b1, 1'b1, b, ad, 1'b1, 1'b0, 1'b0, d);
    endtask

    task automatic rd(input int p, input logic [8:0] ad);
        put(p, 1'b0, 1'b1, 1'b0, 2'b00, ad, 1'b1, 1'b0, 1'b0, 18'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p);
            pipe[p] = 1'b0;
            oe[p] = 1'b1;
        end
        cyc(3);
        rst_n = 1'b1;
        armed = 1;
        // R1: outputs quiet right after reset
        @(negedge clk);
        chk("R1", "dvalid_a", {17'b0, dval[0]}, 18'h0);
        chk("R1", "conflict_b", {17'b0, conf[1]}, 18'h0);
        cyc(2);

        cur = "R4";
        wr(0, 9'h005, 2'b11, 18'h2AB55); cyc(1);
        wr(0, 9'h005, 2'b01, 18'h3FFFF); cyc(1);
        wr(1, 9'h005, 2'b10, 18'h00000); idle(0); cyc(1);
        rd(0, 9'h005); rd(1, 9'h005); cyc(1);
        idle(0); idle(1); cyc(3);

        cur = "R9";
        wr(0, 9'h040, 2'b11, 18'h1C3A5); cyc(1);
        idle(0); rd(1, 9'h040); cyc(1);
        idle(1); cyc(2);

        cur = "R5";
        rd(0, 9'h040); cyc(1);
        rd(0, 9'h005); cyc(1);
        idle(0); cyc(2);

        cur = "R6";
        pipe[1] = 1'b1;
        rd(1, 9'h005); cyc(1);
        rd(1, 9'h040); cyc(1);
        idle(1); cyc(3);
        pipe[1] = 1'b0; cyc(1);

        cur = "R7";
        put(0, 1'b0, 1'b1, 1'b1, 2'b11, 9'h080, 1'b1, 1'b0, 1'b0, 18'h00A01); cyc(1);
        put(0, 1'b0, 1'b1, 1'b1, 2'b11, 9'h000, 1'b0, 1'b1, 1'b0, 18'h00A02); cyc(1);
        put(0, 1'b0, 1'b1, 1'b1, 2'b11, 9'h000, 1'b0, 1'b1, 1'b0, 18'h00A03); cyc(1);
        put(0, 1'b0, 1'b1, 1'b1, 2'b11, 9'h000, 1'b0, 1'b0, 1'b0, 18'h00A04); cyc(1);
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000, 1'b0, 1'b0, 1'b1, 18'h0); cyc(1);
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000, 1'b0, 1'b1, 1'b0, 18'h0); cyc(2);
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000, 1'b0, 1'b0, 1'b0, 18'h0); cyc(1);
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h081, 1'b1, 1'b1, 1'b1, 18'h0); cyc(1);
        pipe[0] = 1'b1;
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000, 1'b0, 1'b0, 1'b1, 18'h0); cyc(1);
        put(0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000, 1'b0, 1'b1, 1'b0, 18'h0); cyc(1);
        idle(0); cyc(3);
        pipe[0] = 1'b0; cyc(1);

        cur = "R8";
        wr(0, 9'h1FF, 2'b11, 18'h1F1F1); cyc(1);
        put(0, 1'b0, 1'b1, 1'b1, 2'b11, 9'h000, 1'b0, 1'b1, 1'b0, 18'h00E0E); cyc(1);
        rd(0, 9'h000); cyc(1);
        rd(0, 9'h1FF); cyc(1);
        idle(0); cyc(2);

        cur = "R3";
        wr(0, 9'h100, 2'b11, 18'h12345); cyc(1);
        put(0, 1'b1, 1'b1, 1'b1, 2'b11, 9'h100, 1'b1, 1'b0, 1'b0, 18'h3AAAA); rd(1, 9'h100); cyc(1);
        put(0, 1'b0, 1'b0, 1'b1, 2'b11, 9'h100, 1'b1, 1'b0, 1'b0, 18'h05555); rd(1, 9'h100); cyc(1);
        put(0, 1'b1, 1'b1, 1'b0, 2'b00, 9'h100, 1'b1, 1'b0, 1'b0, 18'h0); idle(1); cyc(1);
        rd(0, 9'h100); cyc(1);
        idle(0); idle(1); cyc(2);

        cur = "R10";
        wr(1, 9'h03F, 2'b11, 18'h0BEEF); rd(0, 9'h005); cyc(1);
        rd(1, 9'h03F); rd(0, 9'h040); cyc(1);
        cur = "R2";
        wr(1, 9'h045, 2'b11, 18'h2F00D); rd(0, 9'h005); cyc(1);
        rd(1, 9'h045); rd(0, 9'h03F); cyc(1);
        idle(0); idle(1); cyc(2);

        cur = "R11";
        wr(0, 9'h0C0, 2'b11, 18'h11111); wr(1, 9'h0C0, 2'b11, 18'h22222); cyc(1);
        wr(0, 9'h0C1, 2'b01, 18'h13333); wr(1, 9'h0C1, 2'b11, 18'h24444); cyc(1);
        rd(0, 9'h0C0); rd(1, 9'h0C1); cyc(1);
        rd(0, 9'h0C1); rd(1, 9'h0C0); cyc(1);
        idle(0); idle(1); cyc(2);

        cur = "R12";
        oe[0] = 1'b0;
        rd(0, 9'h005); cyc(1);
        rd(0, 9'h0C0); cyc(1);
        idle(0); cyc(1);
        oe[1] = 1'b0; pipe[1] = 1'b1;
        rd(1, 9'h040); cyc(1);
        idle(1); cyc(2);
        oe[0] = 1'b1; oe[1] = 1'b1; pipe[1] = 1'b0;
        cyc(2);

        finish_run();
    end
endmodule